// File: doc/BRIEF.md
# Cascadable Dual-Channel 8-bit Timer

This block holds two independent 8-bit up-counters. Each channel has a control register, a counter register, two compare registers (A and B) and a status register with overflow and compare flags. A channel advances its counter on a count event taken from one of several sources: one of three taps of a shared free-running prescaler, an edge of that channel's external clock pin, or an event from the other channel. The cross-channel source lets the two channels run as one wider counter. Channel 0 counts overflows of channel 1, and channel 1 counts compare-A events of channel 0.

Software drives the block through a simple synchronous register bus. A counter can be cleared by its own compare events or by a capture-B strobe from outside. A flag is cleared by a read-then-write-zero sequence. Each flag raises its interrupt output when the matching enable bit is set.

Top module: `dual_timer8`

## Requirements
- R1: After reset, every control, status, counter and compare register reads 0, every interrupt output is low, and no channel counts.
- R2: Control bits 2:0 equal to 1, 2 or 3 advance the counter once every 8, 64 or 8192 system clock cycles.
- R3: Control bits 2:0 equal to 0 hold the counter. Only a bus write or a capture clear changes it.
- R4: Control bits 2:0 equal to 5, 6 or 7 count falling, rising or both edges of that channel's external pin. The pin passes through a two-flop synchroniser. The other channel's pin has no effect.
- R5: A count event while the counter is 0xFF, with no clear, wraps it to 0x00 and sets status bit 5 (overflow).
- R6: When the counter becomes equal to compare A or compare B, status bit 6 or bit 7 is set. The equality present just after reset does not count.
- R7: Control bits 4:3 select the clear. 00 never clears. 01 loads 0 on the first count event while the counter equals compare A. 10 does so for compare B, and a capture-B strobe also clears at once. 11 clears only on the capture-B strobe.
- R8: Control bits 2:0 equal to 4 make channel 0 count channel 1 overflows and make channel 1 count channel 0 compare-A events.
- R9: When both channels select source 4 at once, neither channel counts.
- R10: A status flag is cleared only by writing 0 to its bit after the bit has been read as 1. Writing 1, or writing 0 without that read, leaves the flag set.
- R11: irq_ovf, irq_cma and irq_cmb are high exactly while their flag is set and control bit 5, 6 or 7 (respectively) is 1.
- R12: Bus address bit 3 picks the channel. Offsets 0 to 4 select control, status, counter, compare A and compare B. Offsets 5 to 7 and status bits 4:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Channel (bit 3) and register offset (bits 2:0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ext_clk | input | 2 | External count pins, one per channel |
| cap_b | input | 2 | Capture-B strobes, one per channel |
| irq_ovf | output | 2 | Overflow interrupt request per channel |
| irq_cma | output | 2 | Compare-A interrupt request per channel |
| irq_cmb | output | 2 | Compare-B interrupt request per channel |

## Verification
The counter is driven by each of the three prescaler taps, measured over a fixed number of cycles. Counting rates that are swapped or off by one tap show up as wrong totals. External pulses are sent in each edge mode, and the totals of 3 or 6 tell falling, rising and both-edge counting apart. Pulses on the other channel's pin check that the pins are not crossed. Short pulse trains walk the counter through 0xFF, through compare A and through compare B under each clear mode. These trains separate a clear that happens at the match from one that happens on the next event, and show that a capture strobe is honoured only in modes 10 and 11. Cascade runs in both directions, and a run with both channels on the cross-channel source, show whether events cross between the channels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DW = 8;

   typedef enum logic [2:0] {
      CK_STOP     = 3'd0,
      CK_TAP_A    = 3'd1,
      CK_TAP_B    = 3'd2,
      CK_TAP_C    = 3'd3,
      CK_CHAIN    = 3'd4,
      CK_EXT_FALL = 3'd5,
      CK_EXT_RISE = 3'd6,
      CK_EXT_BOTH = 3'd7
   } cksel_e;

   typedef enum logic [1:0] {
      CL_NONE  = 2'd0,
      CL_MA    = 2'd1,
      CL_MB_CAP = 2'd2,
      CL_CAP   = 2'd3
   } clrsel_e;

   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd1;
   localparam logic [2:0] OFS_CNT  = 3'd2;
   localparam logic [2:0] OFS_CMPA = 3'd3;
   localparam logic [2:0] OFS_CMPB = 3'd4;

   localparam int BIT_OVF = 5;
   localparam int BIT_MA  = 6;
   localparam int BIT_MB  = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int TAP_A = 3,
   parameter int TAP_B = 6,
   parameter int TAP_C = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] tick
);
   localparam int DIV_W = TAP_C;

   if (!(TAP_A > 0 && TAP_A < TAP_B && TAP_B < TAP_C))
      $error("tmr_prescaler: taps must be strictly increasing and nonzero");

   logic [DIV_W-1:0] div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div <= '0;
      else        div <= div + 1'b1;
   end

   assign tick[0] = &div[TAP_A-1:0];
   assign tick[1] = &div[TAP_B-1:0];
   assign tick[2] = &div[TAP_C-1:0];

   // R2: slower taps fire only on cycles where faster taps also fire
   a_r2_tap_nest_b: assert property (@(posedge clk) disable iff (!rst_n)
      tick[1] |-> tick[0]);
   a_r2_tap_nest_c: assert property (@(posedge clk) disable iff (!rst_n)
      tick[2] |-> tick[1]);
   a_r2_tap_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick[0] |=> !tick[0]);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int LEN = STAGES + 1;

   if (STAGES < 2) $error("tmr_edge_sync: need at least two sync stages");

   logic [LEN-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[LEN-2:0], pin};
   end

   assign rise = sh[LEN-2] & ~sh[LEN-1];
   assign fall = ~sh[LEN-2] & sh[LEN-1];

   a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [2:0]    offs,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [2:0]    tick,
   input  logic          ext_rise,
   input  logic          ext_fall,
   input  logic          chain_evt,
   input  logic          chain_block,
   input  logic          cap_b,
   output logic          src_chain,
   output logic          ma_evt,
   output logic          ovf_evt,
   output logic          irq_ovf,
   output logic          irq_ma,
   output logic          irq_mb
);
   logic [DW-1:0] ctrl, cnt, cmpa, cmpb;
   logic          flg_o, flg_a, flg_b;
   logic          arm_o, arm_a, arm_b;
   logic          eq_a_q, eq_b_q;
   logic          cnt_en, hit_clr, cap_clr, ovf_now, mb_evt;
   logic          wr_ctrl, wr_stat, wr_cnt, wr_cmpa, wr_cmpb, rd_stat;
   cksel_e        cks;
   clrsel_e       clr;

   assign cks = cksel_e'(ctrl[2:0]);
   assign clr = clrsel_e'(ctrl[4:3]);
   assign src_chain = (cks == CK_CHAIN);

   assign wr_ctrl = wr_en && offs == OFS_CTRL;
   assign wr_stat = wr_en && offs == OFS_STAT;
   assign wr_cnt  = wr_en && offs == OFS_CNT;
   assign wr_cmpa = wr_en && offs == OFS_CMPA;
   assign wr_cmpb = wr_en && offs == OFS_CMPB;
   assign rd_stat = rd_en && offs == OFS_STAT;

   always_comb begin
      unique case (cks)
         CK_STOP:     cnt_en = 1'b0;
         CK_TAP_A:    cnt_en = tick[0];
         CK_TAP_B:    cnt_en = tick[1];
         CK_TAP_C:    cnt_en = tick[2];
         CK_CHAIN:    cnt_en = chain_evt && !chain_block;
         CK_EXT_FALL: cnt_en = ext_fall;
         CK_EXT_RISE: cnt_en = ext_rise;
         CK_EXT_BOTH: cnt_en = ext_rise | ext_fall;
         default:     cnt_en = 1'b0;
      endcase
   end

   assign ma_evt  = (cnt == cmpa) && !eq_a_q;
   assign mb_evt  = (cnt == cmpb) && !eq_b_q;
   assign hit_clr = cnt_en && ((clr == CL_MA && cnt == cmpa) ||
                               (clr == CL_MB_CAP && cnt == cmpb));
   assign cap_clr = cap_b && (clr == CL_MB_CAP || clr == CL_CAP);
   assign ovf_now = !wr_cnt && !cap_clr && cnt_en && !hit_clr && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0; cnt <= '0; cmpa <= '0; cmpb <= '0;
         eq_a_q <= 1'b1; eq_b_q <= 1'b1; ovf_evt <= 1'b0;
      end else begin
         eq_a_q  <= (cnt == cmpa);
         eq_b_q  <= (cnt == cmpb);
         ovf_evt <= ovf_now;
         if (wr_ctrl) ctrl <= wdata;
         if (wr_cmpa) cmpa <= wdata;
         if (wr_cmpb) cmpb <= wdata;
         if (wr_cnt)       cnt <= wdata;
         else if (cap_clr) cnt <= '0;
         else if (cnt_en)  cnt <= hit_clr ? '0 : cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_o <= 1'b0; flg_a <= 1'b0; flg_b <= 1'b0;
         arm_o <= 1'b0; arm_a <= 1'b0; arm_b <= 1'b0;
      end else begin
         if (rd_stat && flg_o) arm_o <= 1'b1;
         if (rd_stat && flg_a) arm_a <= 1'b1;
         if (rd_stat && flg_b) arm_b <= 1'b1;
         if (ovf_now) flg_o <= 1'b1;
         else if (wr_stat && arm_o && !wdata[BIT_OVF]) begin
            flg_o <= 1'b0; arm_o <= 1'b0;
         end
         if (ma_evt) flg_a <= 1'b1;
         else if (wr_stat && arm_a && !wdata[BIT_MA]) begin
            flg_a <= 1'b0; arm_a <= 1'b0;
         end
         if (mb_evt) flg_b <= 1'b1;
         else if (wr_stat && arm_b && !wdata[BIT_MB]) begin
            flg_b <= 1'b0; arm_b <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (offs)
         OFS_CTRL: rdata = ctrl;
         OFS_STAT: rdata = {flg_b, flg_a, flg_o, 5'b0};
         OFS_CNT:  rdata = cnt;
         OFS_CMPA: rdata = cmpa;
         OFS_CMPB: rdata = cmpb;
         default:  rdata = '0;
      endcase
   end

   assign irq_ovf = flg_o & ctrl[BIT_OVF];
   assign irq_ma  = flg_a & ctrl[BIT_MA];
   assign irq_mb  = flg_b & ctrl[BIT_MB];

   a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cks == CK_STOP && !wr_cnt && !cap_clr) |=> $stable(cnt));
   a_r9_chain_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_block && cks == CK_CHAIN && !wr_cnt && !cap_clr) |=> $stable(cnt));
   a_r5_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_now |=> (flg_o && cnt == '0));
   a_r6_match_a_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ma_evt |=> flg_a);
   a_r10_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg_o) |-> $past(arm_o));
   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !hit_clr && !wr_cnt && !cap_clr) |=> cnt == $past(cnt) + 8'd1);
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
   import tmr_pkg::*;
#(
   parameter int PRE_A_LOG = 3,
   parameter int PRE_B_LOG = 6,
   parameter int PRE_C_LOG = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic [3:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic [1:0] ext_clk,
   input  logic [1:0] cap_b,
   output logic [1:0] irq_ovf,
   output logic [1:0] irq_cma,
   output logic [1:0] irq_cmb
);
   localparam int NCH = 2;

   logic [2:0]    tick;
   logic [NCH-1:0] rise, fall, src_chain, ma_evt, ovf_evt, chain_in;
   logic [DW-1:0] rd_ch [NCH];
   logic          block;

   tmr_prescaler #(.TAP_A(PRE_A_LOG), .TAP_B(PRE_B_LOG), .TAP_C(PRE_C_LOG))
      u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

   assign block = &src_chain;
   assign chain_in[0] = ovf_evt[1];
   assign chain_in[1] = ma_evt[0];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_me;
      assign sel_me = bus_sel && (bus_addr[3] == i[0]);

      tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .pin(ext_clk[i]),
         .rise(rise[i]), .fall(fall[i]));

      tmr_channel u_ch (
         .clk(clk), .rst_n(rst_n),
         .wr_en(sel_me && bus_wr), .rd_en(sel_me && !bus_wr),
         .offs(bus_addr[2:0]), .wdata(bus_wdata), .rdata(rd_ch[i]),
         .tick(tick), .ext_rise(rise[i]), .ext_fall(fall[i]),
         .chain_evt(chain_in[i]), .chain_block(block), .cap_b(cap_b[i]),
         .src_chain(src_chain[i]), .ma_evt(ma_evt[i]), .ovf_evt(ovf_evt[i]),
         .irq_ovf(irq_ovf[i]), .irq_ma(irq_cma[i]), .irq_mb(irq_cmb[i]));
   end

   assign bus_rdata = rd_ch[bus_addr[3]];
endmodule

// File: tb/dual_timer8_tb.sv
module dual_timer8_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] ext_clk = '0, cap_b = '0;
   logic [1:0] irq_ovf, irq_cma, irq_cmb;
   int total = 0, bad = 0;

   always #5 clk = ~clk;

   dual_timer8 u_dut (.*);

   task automatic chk(string req, int act, int lo, int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(int ch, int ofs, int d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 4'((ch << 3) | ofs); bus_wdata = 8'(d);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(int ch, int ofs, output int d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = 4'((ch << 3) | ofs);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic pulse(int ch, int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); ext_clk[ch] = 1;
         repeat (6) @(negedge clk);
         ext_clk[ch] = 0;
         repeat (6) @(negedge clk);
      end
   endtask

   task automatic strobe(int ch);
      @(negedge clk); cap_b[ch] = 1;
      @(negedge clk); cap_b[ch] = 0;
   endtask

   task automatic t_reset();
      int v;
      for (int ch = 0; ch < 2; ch++)
         for (int o = 0; o < 5; o++) begin
            rd(ch, o, v); chk("R1 reg reset", v, 0, 0);
         end
      chk("R1 irq low", {irq_ovf, irq_cma, irq_cmb}, 0, 0);
      repeat (100) @(negedge clk);
      rd(0, 2, v); chk("R1 stopped", v, 0, 0);
      rd(1, 5, v); chk("R12 unused offset", v, 0, 0);
   endtask

   task automatic t_prescale();
      int v;
      wr(1, 3, 8'h80); wr(1, 4, 8'h80);
      wr(1, 2, 0); wr(1, 0, 1); repeat (800) @(negedge clk);
      rd(1, 2, v); chk("R2 div8", v, 98, 102);
      wr(1, 0, 0); wr(1, 2, 0); wr(1, 0, 2); repeat (640) @(negedge clk);
      rd(1, 2, v); chk("R2 div64", v, 9, 11);
      wr(1, 0, 0); wr(1, 2, 0); wr(1, 0, 3); repeat (8192 * 3) @(negedge clk);
      rd(1, 2, v); chk("R2 div8192", v, 2, 4);
   endtask

   task automatic t_stop();
      int a, b;
      wr(1, 0, 1); repeat (40) @(negedge clk);
      wr(1, 0, 0); rd(1, 2, a);
      repeat (200) @(negedge clk); rd(1, 2, b);
      chk("R3 stopped holds", b, a, a);
   endtask

   task automatic t_ext();
      int v;
      wr(1, 2, 0); wr(1, 0, 5); pulse(1, 3);
      rd(1, 2, v); chk("R4 falling", v, 3, 3);
      wr(1, 2, 0); wr(1, 0, 6); pulse(1, 3);
      rd(1, 2, v); chk("R4 rising", v, 3, 3);
      wr(1, 2, 0); wr(1, 0, 7); pulse(1, 3);
      rd(1, 2, v); chk("R4 both edges", v, 6, 6);
      pulse(0, 2);
      rd(1, 2, v); chk("R4 other pin ignored", v, 6, 6);
      wr(1, 0, 0);
   endtask

   task automatic t_ovf_flags();
      int v;
      wr(0, 3, 8'h80); wr(0, 4, 8'h80); wr(0, 2, 8'hFE);
      wr(0, 0, 8'h06); pulse(0, 2);
      #1 chk("R11 irq_ovf disabled", irq_ovf[0], 0, 0);
      wr(0, 1, 0);
      rd(0, 2, v); chk("R5 wrap", v, 0, 0);
      rd(0, 1, v); chk("R5/R10 ovf flag kept", v, 8'h20, 8'h20);
      wr(0, 0, 8'h26);
      #1 chk("R11 irq_ovf enabled", irq_ovf[0], 1, 1);
      wr(0, 1, 8'h20);
      rd(0, 1, v); chk("R10 writing 1 keeps", v, 8'h20, 8'h20);
      wr(0, 1, 0);
      rd(0, 1, v); chk("R10 cleared", v, 0, 0);
      #1 chk("R11 irq_ovf drops", irq_ovf[0], 0, 0);
   endtask

   task automatic t_cmp_a();
      int v;
      wr(0, 0, 0); wr(0, 2, 0); wr(0, 3, 5); wr(0, 4, 8'hF0);
      wr(0, 0, 8'h4E); pulse(0, 5);
      rd(0, 2, v); chk("R7 sits at match", v, 5, 5);
      rd(0, 1, v); chk("R6 match A flag", v, 8'h40, 8'h40);
      #1 chk("R11 irq_cma", irq_cma[0], 1, 1);
      pulse(0, 2);
      rd(0, 2, v); chk("R7 clear on A", v, 1, 1);
      wr(0, 1, 0);
   endtask

   task automatic t_clear_modes();
      int v;
      wr(0, 0, 0); wr(0, 3, 8'h80); wr(0, 4, 3); wr(0, 2, 0);
      wr(0, 0, 8'h16); pulse(0, 5);
      rd(0, 2, v); chk("R7 clear on B", v, 1, 1);
      rd(0, 1, v); chk("R6 match B flag", v, 8'h80, 8'h80);
      #1 chk("R11 irq_cmb disabled", irq_cmb[0], 0, 0);
      wr(0, 0, 8'h96);
      #1 chk("R11 irq_cmb enabled", irq_cmb[0], 1, 1);
      strobe(0);
      rd(0, 2, v); chk("R7 capture clear mode10", v, 0, 0);
      wr(0, 1, 0);
      wr(0, 0, 8'h1E); pulse(0, 5);
      rd(0, 2, v); chk("R7 mode11 no B clear", v, 5, 5);
      strobe(0);
      rd(0, 2, v); chk("R7 mode11 capture", v, 0, 0);
      wr(0, 0, 8'h06); wr(0, 2, 7); strobe(0);
      rd(0, 2, v); chk("R7 mode00 no clear", v, 7, 7);
      wr(0, 0, 0);
   endtask

   task automatic t_cascade();
      int v;
      wr(0, 3, 2); wr(0, 4, 8'h80); wr(0, 2, 0); wr(0, 0, 8'h0E);
      wr(1, 3, 8'h80); wr(1, 4, 8'h80); wr(1, 2, 0); wr(1, 0, 4);
      pulse(0, 6);
      rd(1, 2, v); chk("R8 ch1 counts ch0 match A", v, 2, 2);
      wr(0, 0, 4); wr(0, 2, 8'h10);
      wr(1, 0, 6); wr(1, 2, 8'hFF); pulse(1, 1);
      rd(1, 2, v); chk("R8 ch1 wrapped", v, 0, 0);
      rd(0, 2, v); chk("R8 ch0 counts ch1 ovf", v, 8'h11, 8'h11);
      wr(1, 0, 4); wr(0, 2, 2);
      repeat (20) @(negedge clk);
      rd(1, 2, v); chk("R9 ch1 blocked", v, 0, 0);
      rd(0, 2, v); chk("R9 ch0 blocked", v, 2, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_prescale();
      t_stop();
      t_ext();
      t_ovf_flags();
      t_cmp_a();
      t_clear_modes();
      t_cascade();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule